// File: doc/BRIEF.md
# End-Around-Carry Word Scrambler

This block is an additive line scrambler for a word-parallel serial link. Its keystream comes from two registers that add into each other once per word with an end-around carry, not from XOR feedback taps. A transmit lane takes a data word with a valid/ready handshake and returns a code word one bit wider than the data. The low bits are the data XOR the first state register, and the top bit is the generator carry as it stood before the step. A receive lane runs the same generator from the same seed. It XORs the received payload with its own keystream and raises an error flag when the received top bit differs from its own carry. A receiver that has lost word alignment sees the same carry-mismatch symptom as a corrupted word.

Both lanes hold the state registers X and Y (W bits each) and a carry C. Each accepted word forms S = X + Y + C, W+1 bits wide. Then C takes S[W], Y takes the old X, and X takes S[W-1:0]. The state does not move while no word is accepted. A synchronous restart reloads both generators from the seed inputs. Two seeds are locked points of the recurrence: all-zero with carry 0, and all-ones with carry 1. Either one is replaced by the default seed X=1, Y=0, C=0, which is also the reset state. The block is used by putting the transmit lane before the serialiser and the receive lane after the deserialiser, with both ends restarted using the same seed.

Top module: `eac_scrambler`

## Requirements
- R1: After reset, both generators hold X=1, Y=0, C=0, neither output is valid, and both lanes are ready.
- R2: A transmit word accepted on a clock edge appears on the code output after that same edge, with the low W bits equal to data XOR X. X follows the recurrence X' = (X+Y+C) mod 2^W, Y' = X, C' = carry out of that sum.
- R3: Bit W (the top bit) of every code word is the generator carry C from before the step that the word caused.
- R4: While restart is high, neither lane accepts input and both output-valid flags are cleared at the next edge. After that edge, the generators hold the seed taken from the seed inputs.
- R5: A seed of X=0, Y=0, C=0 or of X=all-ones, Y=all-ones, C=1 is replaced by the default seed X=1, Y=0, C=0.
- R6: The receive lane outputs received low W bits XOR its own X, one cycle after acceptance, and steps its generator exactly like the transmit lane.
- R7: The receive error flag is 1 exactly when the received bit W differs from the receive generator's carry, and the generator steps whether or not the flag is set.
- R8: While an output is valid and not taken, the code word is held, the lane does not accept input, and its generator state does not change.
- R9: The generator state (X, Y, C) is never all-zero and never all-ones.
- R10: With the downstream side always ready, a lane accepts one word on every clock edge with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| restart_i | input | 1 | Synchronous reload of both generators from the seed inputs |
| seed_x_i | input | W | Seed for register X |
| seed_y_i | input | W | Seed for register Y |
| seed_c_i | input | 1 | Seed for the carry |
| tx_data_i | input | W | Transmit data word |
| tx_valid_i | input | 1 | Transmit data valid |
| tx_ready_o | output | 1 | Transmit lane can accept a word |
| tx_code_o | output | W+1 | Code word: carry at bit W, scrambled data below |
| tx_code_valid_o | output | 1 | Code word valid |
| tx_code_ready_i | input | 1 | Downstream takes the code word |
| rx_code_i | input | W+1 | Received code word |
| rx_valid_i | input | 1 | Received code word valid |
| rx_ready_o | output | 1 | Receive lane can accept a word |
| rx_data_o | output | W | Descrambled data |
| rx_err_o | output | 1 | Carry mismatch for this word |
| rx_valid_o | output | 1 | Descrambled data valid |
| rx_ready_i | input | 1 | Downstream takes the descrambled word |

## Verification
Every result in both lanes comes from one output register. A word accepted on an edge is therefore due on the outputs one edge later, and the next generator state applies to the word accepted on the following edge. The bench drives inputs at the falling edge, lets one rising edge pass, and samples at the next falling edge. Its model state moves only when the bench knows a word was taken. For stalls, the held word is checked at each falling edge while the downstream side stays busy. The word offered during the stall must come out with the keystream of the very next step, which shows the state did not move. A restart is checked by sampling the ready outputs in the restart cycle and the valid outputs one edge later.

// File: rtl/eac_scr_pkg.sv
package eac_scr_pkg;

  // Classification of a requested seed before it reaches the generators.
  typedef enum logic [1:0] {
    SEED_USER      = 2'd0,
    SEED_ZERO_LOCK = 2'd1,
    SEED_ONES_LOCK = 2'd2
  } seed_class_e;

  // Default carry of the fallback seed; X defaults to 1 and Y to 0.
  localparam logic EAC_DEF_CARRY = 1'b0;

  // Stages in the reset release synchroniser.
  localparam int EAC_RST_STAGES = 2;

endpackage

// File: rtl/eac_rst_sync.sv
module eac_rst_sync #(
  parameter int STAGES = eac_scr_pkg::EAC_RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/eac_seed_sel.sv
module eac_seed_sel #(
  parameter int W = 16
) (
  input  logic [W-1:0] req_x_i,
  input  logic [W-1:0] req_y_i,
  input  logic         req_c_i,
  output logic [W-1:0] seed_x_o,
  output logic [W-1:0] seed_y_o,
  output logic         seed_c_o
);
  import eac_scr_pkg::*;

  localparam logic [W-1:0] DEF_X = W'(1);
  localparam logic [W-1:0] DEF_Y = '0;

  seed_class_e cls;

  always_comb begin
    cls = SEED_USER;
    if ((req_x_i == '0) && (req_y_i == '0) && !req_c_i)
      cls = SEED_ZERO_LOCK;
    else if ((&req_x_i) && (&req_y_i) && req_c_i)
      cls = SEED_ONES_LOCK;
  end

  always_comb begin
    if (cls == SEED_USER) begin
      seed_x_o = req_x_i;
      seed_y_o = req_y_i;
      seed_c_o = req_c_i;
    end else begin
      seed_x_o = DEF_X;
      seed_y_o = DEF_Y;
      seed_c_o = EAC_DEF_CARRY;
    end
  end

endmodule

// File: rtl/eac_keygen.sv
module eac_keygen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] seed_x_i,
  input  logic [W-1:0] seed_y_i,
  input  logic         seed_c_i,
  input  logic         step_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic         c_o
);
  import eac_scr_pkg::*;

  localparam int SW = W + 1;

  logic [W-1:0]  x_q, y_q, x_d, y_d;
  logic          c_q, c_d;
  logic [SW-1:0] sum;

  always_comb begin
    sum = {1'b0, x_q} + {1'b0, y_q} + SW'(c_q);
    x_d = x_q;
    y_d = y_q;
    c_d = c_q;
    if (load_i) begin
      x_d = seed_x_i;
      y_d = seed_y_i;
      c_d = seed_c_i;
    end else if (step_i) begin
      x_d = sum[W-1:0];
      y_d = x_q;
      c_d = sum[W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= W'(1);
      y_q <= '0;
      c_q <= EAC_DEF_CARRY;
    end else if (load_i || step_i) begin
      x_q <= x_d;
      y_q <= y_d;
      c_q <= c_d;
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;
  assign c_o = c_q;

endmodule

// File: rtl/eac_tx_lane.sv
module eac_tx_lane #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic [W-1:0] seed_x_i,
  input  logic [W-1:0] seed_y_i,
  input  logic         seed_c_i,
  input  logic [W-1:0] in_data_i,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  output logic [W:0]   out_code_o,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] gen_x_o,
  output logic [W-1:0] gen_y_o,
  output logic         gen_c_o,
  output logic         accept_o
);

  logic [W-1:0] ks_x, ks_y;
  logic         ks_c;
  logic         accept;
  logic [W:0]   code_q, code_d;
  logic         vld_q, vld_d;

  assign in_ready_o = !restart_i && (!vld_q || out_ready_i);
  assign accept     = in_valid_i && in_ready_o;

  eac_keygen #(.W(W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (restart_i),
    .seed_x_i (seed_x_i),
    .seed_y_i (seed_y_i),
    .seed_c_i (seed_c_i),
    .step_i   (accept),
    .x_o      (ks_x),
    .y_o      (ks_y),
    .c_o      (ks_c)
  );

  always_comb begin
    code_d = code_q;
    vld_d  = vld_q;
    if (restart_i) begin
      vld_d = 1'b0;
    end else if (accept) begin
      code_d = {ks_c, in_data_i ^ ks_x};
      vld_d  = 1'b1;
    end else if (out_ready_i) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (accept) code_q <= code_d;
  end

  assign out_code_o  = code_q;
  assign out_valid_o = vld_q;
  assign gen_x_o     = ks_x;
  assign gen_y_o     = ks_y;
  assign gen_c_o     = ks_c;
  assign accept_o    = accept;

endmodule

// File: rtl/eac_rx_lane.sv
module eac_rx_lane #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic [W-1:0] seed_x_i,
  input  logic [W-1:0] seed_y_i,
  input  logic         seed_c_i,
  input  logic [W:0]   in_code_i,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  output logic [W-1:0] out_data_o,
  output logic         out_err_o,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] gen_x_o,
  output logic [W-1:0] gen_y_o,
  output logic         gen_c_o
);

  logic [W-1:0] ks_x, ks_y;
  logic         ks_c;
  logic         accept;
  logic [W-1:0] data_q, data_d;
  logic         err_q, err_d;
  logic         vld_q, vld_d;

  assign in_ready_o = !restart_i && (!vld_q || out_ready_i);
  assign accept     = in_valid_i && in_ready_o;

  eac_keygen #(.W(W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (restart_i),
    .seed_x_i (seed_x_i),
    .seed_y_i (seed_y_i),
    .seed_c_i (seed_c_i),
    .step_i   (accept),
    .x_o      (ks_x),
    .y_o      (ks_y),
    .c_o      (ks_c)
  );

  always_comb begin
    data_d = data_q;
    err_d  = err_q;
    vld_d  = vld_q;
    if (restart_i) begin
      vld_d = 1'b0;
    end else if (accept) begin
      data_d = in_code_i[W-1:0] ^ ks_x;
      err_d  = in_code_i[W] ^ ks_c;
      vld_d  = 1'b1;
    end else if (out_ready_i) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (accept) begin
      data_q <= data_d;
      err_q  <= err_d;
    end
  end

  assign out_data_o  = data_q;
  assign out_err_o   = err_q;
  assign out_valid_o = vld_q;
  assign gen_x_o     = ks_x;
  assign gen_y_o     = ks_y;
  assign gen_c_o     = ks_c;

endmodule

// File: rtl/eac_scrambler.sv
module eac_scrambler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic [W-1:0] seed_x_i,
  input  logic [W-1:0] seed_y_i,
  input  logic         seed_c_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         tx_valid_i,
  output logic         tx_ready_o,
  output logic [W:0]   tx_code_o,
  output logic         tx_code_valid_o,
  input  logic         tx_code_ready_i,
  input  logic [W:0]   rx_code_i,
  input  logic         rx_valid_i,
  output logic         rx_ready_o,
  output logic [W-1:0] rx_data_o,
  output logic         rx_err_o,
  output logic         rx_valid_o,
  input  logic         rx_ready_i
);

  logic         rst_n_sync;
  logic [W-1:0] seed_x, seed_y;
  logic         seed_c;
  logic [W-1:0] tx_x, tx_y, rx_x, rx_y;
  logic         tx_c, rx_c;
  logic         tx_acc;

  eac_rst_sync u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_sync)
  );

  eac_seed_sel #(.W(W)) u_seed (
    .req_x_i  (seed_x_i),
    .req_y_i  (seed_y_i),
    .req_c_i  (seed_c_i),
    .seed_x_o (seed_x),
    .seed_y_o (seed_y),
    .seed_c_o (seed_c)
  );

  eac_tx_lane #(.W(W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .restart_i   (restart_i),
    .seed_x_i    (seed_x),
    .seed_y_i    (seed_y),
    .seed_c_i    (seed_c),
    .in_data_i   (tx_data_i),
    .in_valid_i  (tx_valid_i),
    .in_ready_o  (tx_ready_o),
    .out_code_o  (tx_code_o),
    .out_valid_o (tx_code_valid_o),
    .out_ready_i (tx_code_ready_i),
    .gen_x_o     (tx_x),
    .gen_y_o     (tx_y),
    .gen_c_o     (tx_c),
    .accept_o    (tx_acc)
  );

  eac_rx_lane #(.W(W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .restart_i   (restart_i),
    .seed_x_i    (seed_x),
    .seed_y_i    (seed_y),
    .seed_c_i    (seed_c),
    .in_code_i   (rx_code_i),
    .in_valid_i  (rx_valid_i),
    .in_ready_o  (rx_ready_o),
    .out_data_o  (rx_data_o),
    .out_err_o   (rx_err_o),
    .out_valid_o (rx_valid_o),
    .out_ready_i (rx_ready_i),
    .gen_x_o     (rx_x),
    .gen_y_o     (rx_y),
    .gen_c_o     (rx_c)
  );

endmodule

// File: rtl/eac_scrambler_chk.sv
module eac_scrambler_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n_sync,
  input logic         restart_i,
  input logic [W-1:0] tx_x,
  input logic [W-1:0] tx_y,
  input logic         tx_c,
  input logic [W-1:0] rx_x,
  input logic [W-1:0] rx_y,
  input logic         rx_c,
  input logic         tx_acc,
  input logic         tx_ready_o,
  input logic         rx_ready_o,
  input logic [W:0]   tx_code_o,
  input logic         tx_code_valid_o,
  input logic         tx_code_ready_i,
  input logic         rx_valid_o
);

  AST_TX_STATE_LIVE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !((tx_x == '0) && (tx_y == '0) && !tx_c) && !((&tx_x) && (&tx_y) && tx_c)); // R9

  AST_RX_STATE_LIVE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !((rx_x == '0) && (rx_y == '0) && !rx_c) && !((&rx_x) && (&rx_y) && rx_c)); // R9

  AST_CODE_CARRY_BIT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (tx_acc && !restart_i) |=> (tx_code_o[W] == $past(tx_c))); // R3

  AST_RESTART_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n_sync)
    restart_i |-> (!tx_ready_o && !rx_ready_o)); // R4

  AST_RESTART_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n_sync)
    restart_i |=> (!tx_code_valid_o && !rx_valid_o)); // R4

  AST_STALL_HOLDS_CODE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (tx_code_valid_o && !tx_code_ready_i && !restart_i) |=> (tx_code_valid_o && $stable(tx_code_o))); // R8

  AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!tx_acc && !restart_i) |=> ($stable(tx_x) && $stable(tx_y) && $stable(tx_c))); // R8

endmodule

bind eac_scrambler eac_scrambler_chk #(.W(W)) u_chk (
  .clk             (clk),
  .rst_n_sync      (rst_n_sync),
  .restart_i       (restart_i),
  .tx_x            (tx_x),
  .tx_y            (tx_y),
  .tx_c            (tx_c),
  .rx_x            (rx_x),
  .rx_y            (rx_y),
  .rx_c            (rx_c),
  .tx_acc          (tx_acc),
  .tx_ready_o      (tx_ready_o),
  .rx_ready_o      (rx_ready_o),
  .tx_code_o       (tx_code_o),
  .tx_code_valid_o (tx_code_valid_o),
  .tx_code_ready_i (tx_code_ready_i),
  .rx_valid_o      (rx_valid_o)
);

// File: tb/eac_scrambler_bench.sv
`timescale 1ns/1ps
module eac_scrambler_bench;

  localparam int W = 8;
  localparam int NWORDS = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         restart;
  logic [W-1:0] seed_x, seed_y;
  logic         seed_c;
  logic [W-1:0] tx_data;
  logic         tx_valid, tx_ready;
  logic [W:0]   tx_code;
  logic         tx_code_valid, tx_code_ready;
  logic [W:0]   rx_code;
  logic         rx_valid, rx_ready;
  logic [W-1:0] rx_data;
  logic         rx_err, rx_dvalid, rx_dready;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Bench-side generator models
  logic [W-1:0] tm_x, tm_y, rm_x, rm_y;
  logic         tm_c, rm_c;

  always #2.5 clk = ~clk;

  eac_scrambler #(.W(W)) u_eac_scrambler (
    .clk             (clk),
    .rst_n           (rst_n),
    .restart_i       (restart),
    .seed_x_i        (seed_x),
    .seed_y_i        (seed_y),
    .seed_c_i        (seed_c),
    .tx_data_i       (tx_data),
    .tx_valid_i      (tx_valid),
    .tx_ready_o      (tx_ready),
    .tx_code_o       (tx_code),
    .tx_code_valid_o (tx_code_valid),
    .tx_code_ready_i (tx_code_ready),
    .rx_code_i       (rx_code),
    .rx_valid_i      (rx_valid),
    .rx_ready_o      (rx_ready),
    .rx_data_o       (rx_data),
    .rx_err_o        (rx_err),
    .rx_valid_o      (rx_dvalid),
    .rx_ready_i      (rx_dready)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic adv(inout logic [W-1:0] x, inout logic [W-1:0] y, inout logic c);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y} + (W+1)'(c);
    y = x;
    x = s[W-1:0];
    c = s[W];
  endtask

  task automatic seed_models(input logic [W-1:0] sx, input logic [W-1:0] sy, input logic sc);
    bit lock;
    lock = ((sx == 0) && (sy == 0) && !sc) || ((sx == {W{1'b1}}) && (sy == {W{1'b1}}) && sc);
    if (lock) begin sx = W'(1); sy = '0; sc = 1'b0; end
    tm_x = sx; tm_y = sy; tm_c = sc;
    rm_x = sx; rm_y = sy; rm_c = sc;
  endtask

  // Restart cycle with a word offered on both lanes, which must not be taken.
  task automatic do_restart(input logic [W-1:0] sx, input logic [W-1:0] sy, input logic sc);
    seed_x = sx; seed_y = sy; seed_c = sc;
    restart = 1'b1; tx_valid = 1'b1; rx_valid = 1'b1;
    #1;
    chk(!tx_ready && !rx_ready, "R4 ready low in restart", {tx_ready, rx_ready}, 0);
    @(negedge clk);
    restart = 1'b0; tx_valid = 1'b0; rx_valid = 1'b0;
    chk(!tx_code_valid && !rx_dvalid, "R4 valid cleared", {tx_code_valid, rx_dvalid}, 0);
    seed_models(sx, sy, sc);
  endtask

  // One transmit word; leaves tx_valid high for back-to-back use.
  task automatic tx_word(input logic [W-1:0] d, input string req, output logic [W:0] got);
    logic [W:0] exp;
    tx_data = d; tx_valid = 1'b1;
    #1;
    chk(tx_ready, "R10 tx ready every cycle", tx_ready, 1);
    exp = {tm_c, d ^ tm_x};
    @(negedge clk);
    got = tx_code;
    chk(tx_code_valid && (tx_code == exp), req, {tx_code_valid, tx_code}, {1'b1, exp});
    adv(tm_x, tm_y, tm_c);
  endtask

  task automatic rx_word(input logic [W:0] code, input logic [W-1:0] exp_d, input logic exp_e);
    rx_code = code; rx_valid = 1'b1;
    @(negedge clk);
    chk(rx_dvalid && (rx_data == exp_d), "R6 rx descrambled data", {rx_dvalid, rx_data}, {1'b1, exp_d});
    chk(rx_err == exp_e, "R7 rx carry flag", rx_err, exp_e);
    adv(rm_x, rm_y, rm_c);
  endtask

  initial begin
    logic [W:0] got, prev;
    logic [W-1:0] sx [5];
    logic [W-1:0] sy [5];
    logic         sc [5];
    sx[0] = '0;           sy[0] = '0;           sc[0] = 1'b0;
    sx[1] = {W{1'b1}};    sy[1] = {W{1'b1}};    sc[1] = 1'b1;
    sx[2] = W'(8'h5A);    sy[2] = W'(8'h33);    sc[2] = 1'b1;
    sx[3] = '0;           sy[3] = '0;           sc[3] = 1'b1;
    sx[4] = {W{1'b1}};    sy[4] = '0;           sc[4] = 1'b0;

    rst_n = 1'b0; restart = 1'b0;
    seed_x = '0; seed_y = '0; seed_c = 1'b0;
    tx_data = '0; tx_valid = 1'b0; tx_code_ready = 1'b1;
    rx_code = '0; rx_valid = 1'b0; rx_dready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(!tx_code_valid && !rx_dvalid, "R1 outputs idle after reset", {tx_code_valid, rx_dvalid}, 0);
    chk(tx_ready && rx_ready, "R1 ready after reset", {tx_ready, rx_ready}, 2'b11);
    tm_x = W'(1); tm_y = '0; tm_c = 1'b0;
    rm_x = W'(1); rm_y = '0; rm_c = 1'b0;
    tx_word('0, "R1 first keystream from default seed", got);
    chk(got == {1'b0, W'(1)}, "R1 default seed X=1 C=0", got, {1'b0, W'(1)});
    tx_valid = 1'b0;
    @(negedge clk);

    // R8: stall holds the word and freezes the generator
    tx_word(W'(8'hC3), "R2 word before stall", got);
    tx_code_ready = 1'b0;
    tx_data = W'(8'h3C); tx_valid = 1'b1;
    #1;
    chk(!tx_ready, "R8 not ready while output held", tx_ready, 0);
    repeat (3) begin
      @(negedge clk);
      chk(tx_code_valid && (tx_code == got), "R8 code held during stall", tx_code, got);
    end
    tx_code_ready = 1'b1;
    tx_word(W'(8'h3C), "R8 next word uses the next keystream step", got);
    tx_valid = 1'b0;
    @(negedge clk);

    // Sweeps over all data values for each seed
    for (int s = 0; s < 5; s++) begin
      do_restart(sx[s], sy[s], sc[s]);
      if (s < 2) begin
        // R5: locked seeds fall back to X=1, Y=0, C=0
        tx_word('0, "R5 locked seed replaced by default", got);
        chk(got == {1'b0, W'(1)}, "R5 default keystream", got, {1'b0, W'(1)});
      end
      for (int i = 0; i < NWORDS; i++)
        tx_word(W'(i), "R2 R3 code word", got);
      // R9: with zero data the code exposes X and C; with the previous X it
      // shows the full state, which must be neither all-zero nor all-ones.
      tx_word('0, "R2 zero data", prev);
      for (int i = 0; i < 32; i++) begin
        tx_word('0, "R2 zero data", got);
        chk(!((got == 0) && (prev[W-1:0] == 0)) &&
            !((got == {(W+1){1'b1}}) && (prev[W-1:0] == {W{1'b1}})),
            "R9 state never locked", {got, prev[W-1:0]}, 1);
        prev = got;
      end
      tx_valid = 1'b0;
      @(negedge clk);

      // Receive lane with the same seed; every 7th word has a flipped carry
      do_restart(sx[s], sy[s], sc[s]);
      for (int i = 0; i < NWORDS; i++) begin
        logic [W-1:0] d;
        logic         flip;
        d = W'(i * 5 + 3);
        flip = (i % 7) == 3;
        rx_word({rm_c ^ flip, d ^ rm_x}, d, flip);
      end
      rx_valid = 1'b0;
      @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule